// File: doc/BRIEF.md
# I2C Slave Status Flag Generator

This block produces the status flags and the single interrupt request of an I2C slave that has a receive FIFO and a transmit FIFO. It does not touch the bus. A bus-side engine sends it one-cycle event pulses: a matched address with its direction, the SCL rising and falling edges of the direction bit, a received-byte push, a transmit data pop, and the end of a transfer (STOP or repeated START). The FIFOs report their full and empty states.

Software sees one status byte. Reading it is signalled by a one-cycle strobe, which clears the early-transmit flag. An early-transmit enable selects which SCL edge of the direction bit raises the transmit request. It also selects whether the early-transmit flag follows the transmit FIFO's empty state or acts as a one-shot event per transfer. Two enables gate the receive and transmit requests onto the interrupt line.

Top module: `i2cs_status_top`

## Requirements
- R1: Status bit 4 (receive overflow) is 1 in the cycle after a cycle with `rx_push` and `rx_full` both high, and is 0 after any other cycle.
- R2: Status bit 3 (receive request) is 1 in the cycle after `rx_fifo_empty` is low, and 0 in the cycle after it is high.
- R3: `irq` is a register that equals (bit 3 AND `rx_irq_en`) OR (bit 2 AND `tx_irq_en`), taken from the status of the previous cycle. With both enables low, `irq` stays 0.
- R4: When `early_tx_en` is 0, status bit 2 (transmit request) sets in the cycle after `scl_fall_dir` in a transfer whose matched address carried a read (`addr_rw`=1). `scl_rise_dir` alone leaves it 0.
- R5: When `early_tx_en` is 1, status bit 2 sets in the cycle after `scl_rise_dir` of a matched read.
- R6: Status bit 1 (transmit underflow) sets in the cycle after `scl_rise_dir` or `tx_pop` of a matched read while `tx_fifo_empty` is high.
- R7: When `early_tx_en` is 0, status bit 0 (early transmit) equals `tx_fifo_empty` from the previous cycle.
- R8: When `early_tx_en` is 1, status bit 0 sets in the cycle after `scl_rise_dir` of a matched write (`addr_rw`=0). It sets at most once per transfer, and a `status_rd` strobe clears it.
- R9: `xfer_end` clears bits 2 and 1, forgets the matched address and re-arms the bit 0 one-shot. Direction-bit edges after it have no effect until a new `addr_match`. It takes priority over events in the same cycle.
- R10: Status bits 7 to 5 always read 0, and while `rst` is high all status bits and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_match | input | 1 | Pulse: own address recognised |
| addr_rw | input | 1 | Direction of the matched address, 1 = read |
| scl_rise_dir | input | 1 | Pulse: SCL rising edge during the direction bit |
| scl_fall_dir | input | 1 | Pulse: SCL falling edge during the direction bit |
| xfer_end | input | 1 | Pulse: STOP or repeated START seen |
| rx_push | input | 1 | Pulse: received byte written to the receive FIFO |
| tx_pop | input | 1 | Pulse: master requests a data byte |
| rx_full | input | 1 | Receive FIFO is full |
| rx_fifo_empty | input | 1 | Receive FIFO is empty |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| status_rd | input | 1 | Pulse: status byte read by software |
| early_tx_en | input | 1 | Early-transmit mode select |
| rx_irq_en | input | 1 | Receive request interrupt enable |
| tx_irq_en | input | 1 | Transmit request interrupt enable |
| status | output | 8 | Status byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is the one-shot behaviour of the early-transmit flag in enabled mode. The stimulus has to produce a set, a clearing read, and a second direction-bit rising edge inside the same transfer, which must not set the flag again. Only after an explicit transfer end and a fresh write address match should the flag set once more. The bench first puts the flag into a known 0 state by holding the transmit FIFO non-empty in follow mode. It then switches modes and walks that sequence one cycle at a time, sampling the status byte after each event.

// File: rtl/i2cs_status_pkg.sv
`timescale 1ns/1ps
package i2cs_status_pkg;
  localparam int unsigned FLAG_CNT = 5;
  localparam int unsigned BIT_ETX  = 0;
  localparam int unsigned BIT_TUNF = 1;
  localparam int unsigned BIT_TREQ = 2;
  localparam int unsigned BIT_RREQ = 3;
  localparam int unsigned BIT_ROVF = 4;

  typedef struct packed {
    logic rx_ovf;
    logic rx_req;
    logic tx_req;
    logic tx_unf;
    logic etx;
  } flags_t;
endpackage

// File: rtl/i2cs_rx_flags.sv
`timescale 1ns/1ps
module i2cs_rx_flags (
  input  logic clk,
  input  logic rst,
  input  logic rx_push,
  input  logic rx_full,
  input  logic rx_fifo_empty,
  output logic rx_ovf,
  output logic rx_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ovf <= 1'b0;
      rx_req <= 1'b0;
    end else begin
      rx_ovf <= rx_push & rx_full;
      rx_req <= ~rx_fifo_empty;
    end
  end

  AST_OVF_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full) |=> rx_ovf); // R1
  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !(rx_push && rx_full) |=> !rx_ovf); // R1
  AST_RXREQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !rx_fifo_empty |=> rx_req); // R2
endmodule

// File: rtl/i2cs_tx_flags.sv
`timescale 1ns/1ps
module i2cs_tx_flags (
  input  logic clk,
  input  logic rst,
  input  logic addr_match,
  input  logic addr_rw,
  input  logic scl_rise_dir,
  input  logic scl_fall_dir,
  input  logic xfer_end,
  input  logic tx_pop,
  input  logic tx_fifo_empty,
  input  logic status_rd,
  input  logic early_tx_en,
  output logic tx_req,
  output logic tx_unf,
  output logic etx
);
  logic matched_q;
  logic is_read_q;
  logic etx_done_q;
  logic rd_xfer;
  logic wr_xfer;
  logic req_edge;
  logic etx_fire;

  assign rd_xfer  = matched_q & is_read_q;
  assign wr_xfer  = matched_q & ~is_read_q;
  assign req_edge = early_tx_en ? scl_rise_dir : scl_fall_dir;
  assign etx_fire = wr_xfer & scl_rise_dir & ~etx_done_q;

  // transfer tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      matched_q <= 1'b0;
      is_read_q <= 1'b0;
    end else if (xfer_end) begin
      matched_q <= 1'b0;
      is_read_q <= 1'b0;
    end else if (addr_match) begin
      matched_q <= 1'b1;
      is_read_q <= addr_rw;
    end
  end

  // transmit request and underflow
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req <= 1'b0;
      tx_unf <= 1'b0;
    end else if (xfer_end) begin
      tx_req <= 1'b0;
      tx_unf <= 1'b0;
    end else begin
      if (rd_xfer && req_edge)
        tx_req <= 1'b1;
      if (rd_xfer && (scl_rise_dir || tx_pop) && tx_fifo_empty)
        tx_unf <= 1'b1;
    end
  end

  // early transmit flag and its once-per-transfer latch
  always_ff @(posedge clk) begin
    if (rst) begin
      etx        <= 1'b0;
      etx_done_q <= 1'b0;
    end else begin
      if (xfer_end)
        etx_done_q <= 1'b0;
      else if (early_tx_en && etx_fire)
        etx_done_q <= 1'b1;

      if (!early_tx_en)
        etx <= tx_fifo_empty;
      else if (etx_fire && !xfer_end)
        etx <= 1'b1;
      else if (status_rd)
        etx <= 1'b0;
    end
  end

  AST_TXREQ_LATE: assert property (@(posedge clk) disable iff (rst)
    (rd_xfer && !early_tx_en && scl_fall_dir && !xfer_end) |=> tx_req); // R4
  AST_TXREQ_EARLY: assert property (@(posedge clk) disable iff (rst)
    (rd_xfer && early_tx_en && scl_rise_dir && !xfer_end) |=> tx_req); // R5
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_xfer && scl_rise_dir && tx_fifo_empty && !xfer_end) |=> tx_unf); // R6
  AST_ETX_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !early_tx_en |=> (etx == $past(tx_fifo_empty))); // R7
  AST_ETX_READ_CLR: assert property (@(posedge clk) disable iff (rst)
    (early_tx_en && status_rd && !scl_rise_dir) |=> !etx); // R8
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    xfer_end |=> (!tx_req && !tx_unf && !matched_q)); // R9
endmodule

// File: rtl/i2cs_irq_gen.sv
`timescale 1ns/1ps
module i2cs_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic rx_req,
  input  logic tx_req,
  input  logic rx_irq_en,
  input  logic tx_irq_en,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (rx_req & rx_irq_en) | (tx_req & tx_irq_en);
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!rx_irq_en && !tx_irq_en) |=> !irq); // R3
  AST_IRQ_RX: assert property (@(posedge clk) disable iff (rst)
    (rx_req && rx_irq_en) |=> irq); // R3
endmodule

// File: rtl/i2cs_status_top.sv
`timescale 1ns/1ps
module i2cs_status_top #(
  parameter int unsigned STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                addr_match,
  input  logic                addr_rw,
  input  logic                scl_rise_dir,
  input  logic                scl_fall_dir,
  input  logic                xfer_end,
  input  logic                rx_push,
  input  logic                tx_pop,
  input  logic                rx_full,
  input  logic                rx_fifo_empty,
  input  logic                tx_fifo_empty,
  input  logic                status_rd,
  input  logic                early_tx_en,
  input  logic                rx_irq_en,
  input  logic                tx_irq_en,
  output logic [STATUS_W-1:0] status,
  output logic                irq
);
  import i2cs_status_pkg::*;

  localparam int unsigned PAD_W = STATUS_W - FLAG_CNT;

  flags_t fl;

  i2cs_rx_flags u_rx (
    .clk(clk), .rst(rst), .rx_push(rx_push), .rx_full(rx_full),
    .rx_fifo_empty(rx_fifo_empty), .rx_ovf(fl.rx_ovf), .rx_req(fl.rx_req)
  );

  i2cs_tx_flags u_tx (
    .clk(clk), .rst(rst), .addr_match(addr_match), .addr_rw(addr_rw),
    .scl_rise_dir(scl_rise_dir), .scl_fall_dir(scl_fall_dir),
    .xfer_end(xfer_end), .tx_pop(tx_pop), .tx_fifo_empty(tx_fifo_empty),
    .status_rd(status_rd), .early_tx_en(early_tx_en),
    .tx_req(fl.tx_req), .tx_unf(fl.tx_unf), .etx(fl.etx)
  );

  i2cs_irq_gen u_irq (
    .clk(clk), .rst(rst), .rx_req(fl.rx_req), .tx_req(fl.tx_req),
    .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en), .irq(irq)
  );

  always_comb begin
    status = '0;
    status[BIT_ROVF] = fl.rx_ovf;
    status[BIT_RREQ] = fl.rx_req;
    status[BIT_TREQ] = fl.tx_req;
    status[BIT_TUNF] = fl.tx_unf;
    status[BIT_ETX]  = fl.etx;
  end

  generate
    if (PAD_W > 0) begin : g_pad_chk
      AST_PAD_ZERO: assert property (@(posedge clk)
        status[STATUS_W-1:FLAG_CNT] == '0); // R10
    end
  endgenerate
endmodule

// File: tb/i2cs_status_top_tb_top.sv
`timescale 1ns/1ps
module i2cs_status_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_match = 0, addr_rw = 0, scl_rise_dir = 0, scl_fall_dir = 0;
  logic xfer_end = 0, rx_push = 0, tx_pop = 0, rx_full = 0;
  logic rx_fifo_empty = 1, tx_fifo_empty = 0, status_rd = 0;
  logic early_tx_en = 0, rx_irq_en = 0, tx_irq_en = 0;
  logic [7:0] status;
  logic irq;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  i2cs_status_top dut_i (
    .clk(clk), .rst(rst), .addr_match(addr_match), .addr_rw(addr_rw),
    .scl_rise_dir(scl_rise_dir), .scl_fall_dir(scl_fall_dir),
    .xfer_end(xfer_end), .rx_push(rx_push), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_fifo_empty(rx_fifo_empty),
    .tx_fifo_empty(tx_fifo_empty), .status_rd(status_rd),
    .early_tx_en(early_tx_en), .rx_irq_en(rx_irq_en),
    .tx_irq_en(tx_irq_en), .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // inputs change just after a falling edge; one rising edge registers them
  task automatic step();
    @(negedge clk);
    addr_match = 0; scl_rise_dir = 0; scl_fall_dir = 0; xfer_end = 0;
    rx_push = 0; tx_pop = 0; status_rd = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset status", status, 8'h00);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
    rst = 0;
    step();
    chk("R10 upper bits zero", {5'b0, status[7:5]}, 8'h00);
  endtask

  task automatic t_rx();
    rx_fifo_empty = 0; step();
    chk("R2 rx request set", {7'b0, status[3]}, 8'h01);
    step();
    chk("R3 irq masked", {7'b0, irq}, 8'h00);
    rx_irq_en = 1; step(); step();
    chk("R3 irq rx enabled", {7'b0, irq}, 8'h01);
    rx_fifo_empty = 1; step();
    chk("R2 rx request clear", {7'b0, status[3]}, 8'h00);
    rx_irq_en = 0;
    rx_push = 1; rx_full = 1; step();
    chk("R1 overflow set", {7'b0, status[4]}, 8'h01);
    step();
    chk("R1 overflow clears", {7'b0, status[4]}, 8'h00);
    rx_full = 0; rx_push = 1; step();
    chk("R1 push not full", {7'b0, status[4]}, 8'h00);
  endtask

  task automatic t_read_late();
    early_tx_en = 0; tx_fifo_empty = 0;
    addr_match = 1; addr_rw = 1; step();
    scl_rise_dir = 1; step();
    chk("R4 rise ignored", {7'b0, status[2]}, 8'h00);
    tx_irq_en = 1;
    scl_fall_dir = 1; step();
    chk("R4 fall sets tx request", {7'b0, status[2]}, 8'h01);
    step();
    chk("R3 irq tx enabled", {7'b0, irq}, 8'h01);
    tx_irq_en = 0;
    xfer_end = 1; step();
    chk("R9 end clears tx bits", {6'b0, status[2:1]}, 8'h00);
    scl_fall_dir = 1; step();
    chk("R9 edge after end ignored", {7'b0, status[2]}, 8'h00);
  endtask

  task automatic t_read_early();
    early_tx_en = 1;
    addr_match = 1; addr_rw = 1; step();
    scl_rise_dir = 1; step();
    chk("R5 rise sets tx request", {7'b0, status[2]}, 8'h01);
    xfer_end = 1; step();
    tx_fifo_empty = 1;
    addr_match = 1; addr_rw = 1; step();
    chk("R6 no underflow before edge", {7'b0, status[1]}, 8'h00);
    scl_rise_dir = 1; step();
    chk("R6 underflow set", {7'b0, status[1]}, 8'h01);
    xfer_end = 1; step();
    chk("R9 underflow cleared", {7'b0, status[1]}, 8'h00);
    tx_fifo_empty = 0;
  endtask

  task automatic t_etx_follow();
    early_tx_en = 0; tx_fifo_empty = 1; step();
    chk("R7 follows empty", {7'b0, status[0]}, 8'h01);
    status_rd = 1; step();
    chk("R7 read has no effect", {7'b0, status[0]}, 8'h01);
    tx_fifo_empty = 0; step();
    chk("R7 follows not empty", {7'b0, status[0]}, 8'h00);
  endtask

  task automatic t_etx_once();
    early_tx_en = 1; step();
    addr_match = 1; addr_rw = 0; step();
    chk("R8 idle before edge", {7'b0, status[0]}, 8'h00);
    scl_rise_dir = 1; step();
    chk("R8 write rise sets", {7'b0, status[0]}, 8'h01);
    step();
    chk("R8 holds until read", {7'b0, status[0]}, 8'h01);
    status_rd = 1; step();
    chk("R8 read clears", {7'b0, status[0]}, 8'h00);
    scl_rise_dir = 1; step();
    chk("R8 once per transfer", {7'b0, status[0]}, 8'h00);
    xfer_end = 1; step();
    addr_match = 1; addr_rw = 0; step();
    scl_rise_dir = 1; step();
    chk("R9 re-armed after end", {7'b0, status[0]}, 8'h01);
    chk("R10 upper bits zero", {5'b0, status[7:5]}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rx();
    t_read_late();
    t_read_early();
    t_etx_follow();
    t_etx_once();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule